// File: doc/BRIEF.md
# Channel-Status and User-Bit Triple Buffer

This block holds the per-block side information of a digital audio transceiver: one block of channel-status bits and one block of user bits. Each kind of bit passes through three stages. A capture stage fills from the bits that the receive path extracts from the incoming line. A host stage can be read and written a byte at a time. A transmit stage feeds the outgoing encoder one bit per subframe. Whole-block copies move data forward on their own. When the capture stage has collected a full block, all of it moves into the host stage in a single clock. When the encoder starts a new outgoing block, the host stage moves into the transmit stage in a single clock, so no outgoing block mixes two host-stage snapshots.

A block holds `BLK_BITS` (384) bits. Bit `2n` belongs to subframe A of frame `n` and bit `2n+1` to subframe B, starting from frame 0. Host byte address `k` covers buffer bits `8k` to `8k+7`, with bit 0 of the byte at buffer bit `8k`. A host select bit picks the channel-status set or the user set. The block works only while its run enable and both clock-running indications are high.

The capture stage has two states: `RX_HUNT` waits for a block-start bit, and `RX_FILL` writes consecutive indexes. A bit marked as block start moves the stage from either state to `RX_FILL`. Writing the last index moves it back to `RX_HUNT`. The transmit stage has two states: `TX_IDLE` answers no request, and `TX_SEND` walks through the transmit buffer. A request marked as block start moves it from either state to `TX_SEND`, and loss of activity returns it to `TX_IDLE`. The host stage decides each cycle among three operations: `HS_COPY`, `HS_WRITE` and `HS_IDLE`, in that order of priority.

Top module: `chsb_triple_buffer`

## Requirements
- R1: After reset, `tx_bit_vld`, `host_rvld`, `host_rdata` and `e_updated` are 0, and every buffer bit reads 0.
- R2: An active receive strobe with `rx_blk_start` high writes `rx_c_bit`/`rx_u_bit` at index 0. Each later strobe without block start writes the next index. A strobe without block start while hunting is ignored.
- R3: The strobe that writes index 383 copies the whole capture block, including that bit, into the host stage. A block start before index 383 restarts the fill at index 0 and discards the partial block with no copy.
- R4: A host access has `host_sel` high. A write (`host_wr`=1) changes byte `host_addr` of the channel-status set when `host_bsel`=0 and of the user set when `host_bsel`=1, effective at that clock edge. A read returns the byte in `host_rdata` with `host_rvld` high one cycle later.
- R5: When a host write and a capture-to-host copy fall in the same cycle, the copy wins and the write is lost.
- R6: `e_updated` goes high in the cycle after a capture-to-host copy. Any host read clears it in the next cycle, unless a copy happens in the same cycle, in which case the flag stays high.
- R7: Every active `tx_bit_req` after a transmit block start is answered one cycle later with `tx_bit_vld`=1 and the bit pair on `tx_c_bit`/`tx_u_bit`. Requests before any block start get no answer.
- R8: A request with `tx_blk_start` copies the host stage into the transmit stage and answers with index 0 of that new content. Host writes made during an outgoing block do not change the bits of that block.
- R9: After index 383 has been sent and no new block start arrives, the next request sends index 0 of the same transmit block again.
- R10: The block is active only while `run_en`, `rx_clk_ok` and `tx_clk_ok` are all high. While inactive, receive strobes and host writes are ignored, host reads return 0 with `host_rvld`, and no transmit request is answered. Buffer contents are kept. Capture returns to hunting and transmit returns to idle.
- R11: Host addresses 48 and above address nothing: writes to them change no byte, and reads of them return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset |
| run_en | input | 1 | Run control enable |
| rx_clk_ok | input | 1 | Receive-side clock running |
| tx_clk_ok | input | 1 | Output-side clock running |
| rx_bit_vld | input | 1 | Strobe for one extracted side-bit pair |
| rx_blk_start | input | 1 | Current strobe is index 0 of a block |
| rx_c_bit | input | 1 | Extracted channel-status bit |
| rx_u_bit | input | 1 | Extracted user bit |
| tx_bit_req | input | 1 | Encoder requests the next bit pair |
| tx_blk_start | input | 1 | Current request opens an outgoing block |
| tx_bit_vld | output | 1 | Answer to the previous-cycle request |
| tx_c_bit | output | 1 | Channel-status bit to send |
| tx_u_bit | output | 1 | User bit to send |
| host_sel | input | 1 | Host access strobe |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_bsel | input | 1 | 0 = channel-status set, 1 = user set |
| host_addr | input | ADDR_W | Byte address within the buffer |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data |
| host_rvld | output | 1 | Read data valid |
| e_updated | output | 1 | Host stage was refreshed by capture |

## Verification
Every result of this block appears exactly one clock after the stimulus that causes it. A read request produces `host_rdata` at the next edge. A transmit request produces its bit pair at the next edge. The strobe carrying bit 383 raises `e_updated` and the new host-stage contents at that same edge. The bench drives each stimulus on a falling edge and, at the same moment, queues the expected answer from its own model of the three stages. A monitor compares the queue against the outputs on the next falling edge, so each comparison lands half a cycle after the registering edge. Any answer that appears with an empty queue counts as a failure.

// File: rtl/chsb_pkg.sv
package chsb_pkg;

    // One side-information block: 192 frames times two subframes.
    localparam int BLK_BITS_DEF = 384;
    // Host port lane width; byte k covers buffer bits 8k .. 8k+7.
    localparam int HOST_LANE = 8;

    typedef enum logic {
        RX_HUNT,
        RX_FILL
    } rx_state_e;

    typedef enum logic {
        TX_IDLE,
        TX_SEND
    } tx_state_e;

    typedef enum logic [1:0] {
        HS_IDLE,
        HS_WRITE,
        HS_COPY
    } host_op_e;

endpackage

// File: rtl/chsb_rx_capture.sv
module chsb_rx_capture
    import chsb_pkg::*;
#(
    parameter int BLK_BITS = BLK_BITS_DEF
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                active,
    input  logic                bit_vld,
    input  logic                blk_start,
    input  logic                c_bit,
    input  logic                u_bit,
    output logic                copy_de,
    output logic [BLK_BITS-1:0] snap_c,
    output logic [BLK_BITS-1:0] snap_u
);

    localparam int PTR_W = $clog2(BLK_BITS);
    localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(BLK_BITS - 1);

    rx_state_e           state_q, state_d;
    logic [PTR_W-1:0]    ptr_q, ptr_d;
    logic [BLK_BITS-1:0] d_c_q, d_u_q, d_c_d, d_u_d;
    logic                wr_en;
    logic [PTR_W-1:0]    wr_idx;
    logic                copy_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RX_HUNT;
            ptr_q   <= '0;
            d_c_q   <= '0;
            d_u_q   <= '0;
        end else begin
            state_q <= state_d;
            ptr_q   <= ptr_d;
            d_c_q   <= d_c_d;
            d_u_q   <= d_u_d;
        end
    end

    // Next state and fill control
    always_comb begin
        state_d = state_q;
        ptr_d   = ptr_q;
        wr_en   = 1'b0;
        wr_idx  = ptr_q;
        copy_d  = 1'b0;
        if (!active) begin
            state_d = RX_HUNT;
            ptr_d   = '0;
        end else if (bit_vld) begin
            if (blk_start) begin
                wr_en   = 1'b1;
                wr_idx  = '0;
                state_d = RX_FILL;
                ptr_d   = PTR_W'(1);
            end else begin
                unique case (state_q)
                    RX_HUNT: begin
                        wr_en = 1'b0;
                    end
                    RX_FILL: begin
                        wr_en  = 1'b1;
                        wr_idx = ptr_q;
                        if (ptr_q == LAST_IDX) begin
                            copy_d  = 1'b1;
                            state_d = RX_HUNT;
                            ptr_d   = '0;
                        end else begin
                            ptr_d = ptr_q + PTR_W'(1);
                        end
                    end
                endcase
            end
        end
    end

    // Capture buffers with the incoming bit merged in
    always_comb begin
        d_c_d = d_c_q;
        d_u_d = d_u_q;
        if (wr_en) begin
            d_c_d[wr_idx] = c_bit;
            d_u_d[wr_idx] = u_bit;
        end
    end

    // Outputs
    assign copy_de = copy_d;
    assign snap_c  = d_c_d;
    assign snap_u  = d_u_d;

    AST_RX_PTR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_q <= LAST_IDX); // R2
    AST_RX_COPY_ENDS_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        copy_de |=> (state_q == RX_HUNT && ptr_q == '0)); // R3
    AST_RX_OFF_HUNTS: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (state_q == RX_HUNT && ptr_q == '0)); // R10

endmodule

// File: rtl/chsb_host_stage.sv
module chsb_host_stage
    import chsb_pkg::*;
#(
    parameter int BLK_BITS = BLK_BITS_DEF,
    parameter int ADDR_W   = $clog2(BLK_BITS / HOST_LANE)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 active,
    input  logic                 copy_de,
    input  logic [BLK_BITS-1:0]  snap_c,
    input  logic [BLK_BITS-1:0]  snap_u,
    input  logic                 host_sel,
    input  logic                 host_wr,
    input  logic                 host_bsel,
    input  logic [ADDR_W-1:0]    host_addr,
    input  logic [HOST_LANE-1:0] host_wdata,
    output logic [HOST_LANE-1:0] host_rdata,
    output logic                 host_rvld,
    output logic                 e_updated,
    output logic [BLK_BITS-1:0]  e_c,
    output logic [BLK_BITS-1:0]  e_u
);

    localparam int N_BYTES = BLK_BITS / HOST_LANE;
    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(N_BYTES - 1);

    host_op_e              op;
    logic [BLK_BITS-1:0]   e_c_q, e_u_q, e_c_d, e_u_d;
    logic [ADDR_W+2:0]     base;
    logic                  addr_ok;
    logic                  rd_acc;
    logic [HOST_LANE-1:0]  rd_byte;
    logic [HOST_LANE-1:0]  rdata_q;
    logic                  rvld_q;
    logic                  upd_q;

    assign base    = {host_addr, 3'b000};
    assign addr_ok = (host_addr <= LAST_ADDR);
    assign rd_acc  = host_sel && !host_wr;

    // Operation select: copy beats a host write
    always_comb begin
        if (copy_de) begin
            op = HS_COPY;
        end else if (active && host_sel && host_wr && addr_ok) begin
            op = HS_WRITE;
        end else begin
            op = HS_IDLE;
        end
    end

    always_comb begin
        e_c_d = e_c_q;
        e_u_d = e_u_q;
        unique case (op)
            HS_COPY: begin
                e_c_d = snap_c;
                e_u_d = snap_u;
            end
            HS_WRITE: begin
                if (host_bsel) begin
                    e_u_d[base +: HOST_LANE] = host_wdata;
                end else begin
                    e_c_d[base +: HOST_LANE] = host_wdata;
                end
            end
            HS_IDLE: begin
                e_c_d = e_c_q;
            end
            default: begin
                e_c_d = e_c_q;
            end
        endcase
    end

    assign rd_byte = host_bsel ? e_u_q[base +: HOST_LANE] : e_c_q[base +: HOST_LANE];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            e_c_q   <= '0;
            e_u_q   <= '0;
            rdata_q <= '0;
            rvld_q  <= 1'b0;
            upd_q   <= 1'b0;
        end else begin
            e_c_q   <= e_c_d;
            e_u_q   <= e_u_d;
            rvld_q  <= rd_acc;
            rdata_q <= (rd_acc && active && addr_ok) ? rd_byte : '0;
            if (copy_de) begin
                upd_q <= 1'b1;
            end else if (rd_acc) begin
                upd_q <= 1'b0;
            end
        end
    end

    assign host_rdata = rdata_q;
    assign host_rvld  = rvld_q;
    assign e_updated  = upd_q;
    assign e_c        = e_c_q;
    assign e_u        = e_u_q;

    AST_FLAG_AFTER_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        copy_de |=> e_updated); // R6
    AST_COPY_LOADS_E: assert property (@(posedge clk) disable iff (!rst_n)
        copy_de |=> (e_c == $past(snap_c) && e_u == $past(snap_u))); // R5
    AST_E_HELD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> ($stable(e_c) && $stable(e_u))); // R10
    AST_RD_ZERO_BAD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (host_sel && !host_wr && !addr_ok) |=> (host_rvld && host_rdata == '0)); // R11

endmodule

// File: rtl/chsb_tx_stage.sv
module chsb_tx_stage
    import chsb_pkg::*;
#(
    parameter int BLK_BITS = BLK_BITS_DEF
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                active,
    input  logic                bit_req,
    input  logic                blk_start,
    input  logic [BLK_BITS-1:0] e_c,
    input  logic [BLK_BITS-1:0] e_u,
    output logic                tx_bit_vld,
    output logic                tx_c,
    output logic                tx_u
);

    localparam int PTR_W = $clog2(BLK_BITS);
    localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(BLK_BITS - 1);

    tx_state_e           state_q, state_d;
    logic [PTR_W-1:0]    ptr_q, ptr_d;
    logic [BLK_BITS-1:0] f_c_q, f_u_q;
    logic                load_f;
    logic                vld_d, c_d, u_d;
    logic                vld_q, c_q, u_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TX_IDLE;
            ptr_q   <= '0;
            f_c_q   <= '0;
            f_u_q   <= '0;
        end else begin
            state_q <= state_d;
            ptr_q   <= ptr_d;
            if (load_f) begin
                f_c_q <= e_c;
                f_u_q <= e_u;
            end
        end
    end

    // Next state, transfer and bit selection
    always_comb begin
        state_d = state_q;
        ptr_d   = ptr_q;
        load_f  = 1'b0;
        vld_d   = 1'b0;
        c_d     = 1'b0;
        u_d     = 1'b0;
        if (!active) begin
            state_d = TX_IDLE;
            ptr_d   = '0;
        end else if (bit_req) begin
            if (blk_start) begin
                load_f  = 1'b1;
                vld_d   = 1'b1;
                c_d     = e_c[0];
                u_d     = e_u[0];
                state_d = TX_SEND;
                ptr_d   = PTR_W'(1);
            end else begin
                unique case (state_q)
                    TX_IDLE: begin
                        vld_d = 1'b0;
                    end
                    TX_SEND: begin
                        vld_d = 1'b1;
                        c_d   = f_c_q[ptr_q];
                        u_d   = f_u_q[ptr_q];
                        ptr_d = (ptr_q == LAST_IDX) ? '0 : ptr_q + PTR_W'(1);
                    end
                endcase
            end
        end
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= 1'b0;
            c_q   <= 1'b0;
            u_q   <= 1'b0;
        end else begin
            vld_q <= vld_d;
            c_q   <= c_d;
            u_q   <= u_d;
        end
    end

    assign tx_bit_vld = vld_q;
    assign tx_c       = c_q;
    assign tx_u       = u_q;

    AST_TX_VLD_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        tx_bit_vld |-> $past(bit_req && active)); // R7
    AST_F_ONLY_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
        !(active && bit_req && blk_start) |=> ($stable(f_c_q) && $stable(f_u_q))); // R8
    AST_TX_FIRST_FROM_E: assert property (@(posedge clk) disable iff (!rst_n)
        (active && bit_req && blk_start) |=> (tx_bit_vld && tx_c == $past(e_c[0]) && tx_u == $past(e_u[0]))); // R8
    AST_TX_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> !tx_bit_vld); // R10

endmodule

// File: rtl/chsb_triple_buffer.sv
module chsb_triple_buffer
    import chsb_pkg::*;
#(
    parameter int BLK_BITS = BLK_BITS_DEF,
    parameter int ADDR_W   = $clog2(BLK_BITS / HOST_LANE)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 run_en,
    input  logic                 rx_clk_ok,
    input  logic                 tx_clk_ok,
    input  logic                 rx_bit_vld,
    input  logic                 rx_blk_start,
    input  logic                 rx_c_bit,
    input  logic                 rx_u_bit,
    input  logic                 tx_bit_req,
    input  logic                 tx_blk_start,
    output logic                 tx_bit_vld,
    output logic                 tx_c_bit,
    output logic                 tx_u_bit,
    input  logic                 host_sel,
    input  logic                 host_wr,
    input  logic                 host_bsel,
    input  logic [ADDR_W-1:0]    host_addr,
    input  logic [HOST_LANE-1:0] host_wdata,
    output logic [HOST_LANE-1:0] host_rdata,
    output logic                 host_rvld,
    output logic                 e_updated
);

    logic                active;
    logic                copy_de;
    logic [BLK_BITS-1:0] snap_c, snap_u;
    logic [BLK_BITS-1:0] e_c, e_u;

    assign active = run_en && rx_clk_ok && tx_clk_ok;

    chsb_rx_capture #(.BLK_BITS(BLK_BITS)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (active),
        .bit_vld   (rx_bit_vld),
        .blk_start (rx_blk_start),
        .c_bit     (rx_c_bit),
        .u_bit     (rx_u_bit),
        .copy_de   (copy_de),
        .snap_c    (snap_c),
        .snap_u    (snap_u)
    );

    chsb_host_stage #(.BLK_BITS(BLK_BITS), .ADDR_W(ADDR_W)) u_host (
        .clk        (clk),
        .rst_n      (rst_n),
        .active     (active),
        .copy_de    (copy_de),
        .snap_c     (snap_c),
        .snap_u     (snap_u),
        .host_sel   (host_sel),
        .host_wr    (host_wr),
        .host_bsel  (host_bsel),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .host_rvld  (host_rvld),
        .e_updated  (e_updated),
        .e_c        (e_c),
        .e_u        (e_u)
    );

    chsb_tx_stage #(.BLK_BITS(BLK_BITS)) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .active     (active),
        .bit_req    (tx_bit_req),
        .blk_start  (tx_blk_start),
        .e_c        (e_c),
        .e_u        (e_u),
        .tx_bit_vld (tx_bit_vld),
        .tx_c       (tx_c_bit),
        .tx_u       (tx_u_bit)
    );

    AST_COPY_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        copy_de |-> (run_en && rx_clk_ok && tx_clk_ok)); // R10

endmodule

// File: tb/sim_chsb_triple_buffer.sv
`timescale 1ns/1ps
module sim_chsb_triple_buffer;

    localparam int BLK = 384;
    localparam int NB  = 48;
    localparam int AW  = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic run_en = 1'b1, rx_clk_ok = 1'b1, tx_clk_ok = 1'b1;
    logic rx_bit_vld = 1'b0, rx_blk_start = 1'b0, rx_c_bit = 1'b0, rx_u_bit = 1'b0;
    logic tx_bit_req = 1'b0, tx_blk_start = 1'b0;
    logic tx_bit_vld, tx_c_bit, tx_u_bit;
    logic host_sel = 1'b0, host_wr = 1'b0, host_bsel = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic host_rvld, e_updated;

    chsb_triple_buffer #(.BLK_BITS(BLK), .ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .rx_clk_ok(rx_clk_ok), .tx_clk_ok(tx_clk_ok),
        .rx_bit_vld(rx_bit_vld), .rx_blk_start(rx_blk_start), .rx_c_bit(rx_c_bit), .rx_u_bit(rx_u_bit),
        .tx_bit_req(tx_bit_req), .tx_blk_start(tx_blk_start), .tx_bit_vld(tx_bit_vld),
        .tx_c_bit(tx_c_bit), .tx_u_bit(tx_u_bit), .host_sel(host_sel), .host_wr(host_wr),
        .host_bsel(host_bsel), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .host_rvld(host_rvld), .e_updated(e_updated)
    );

    always #4 clk = ~clk;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    // Bench model of the stages
    logic [BLK-1:0] m_e_c = '0, m_e_u = '0, m_f_c = '0, m_f_u = '0;
    int  t_ptr = 0;
    bit  t_on = 1'b0;
    bit  m_act = 1'b1;
    bit  m_flag = 1'b0;

    logic [1:0] q_tx[$];
    string      q_tx_tag[$];
    logic [7:0] q_rd[$];
    string      q_rd_tag[$];

    function automatic logic pc(int p, int i);
        return ((i * 3 + p) % 5) < 2;
    endfunction

    function automatic logic pu(int p, int i);
        return ((i + p * 7) % 3) == 0;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: pops expected results as the design produces them
    always @(negedge clk) begin : mon
        logic [1:0] etx;
        logic [7:0] erd;
        string      tg;
        if (rst_n) begin
            if (tx_bit_vld) begin
                if (q_tx.size() == 0) begin
                    n_chk++;
                    n_err++;
                    $display("FAIL R7 actual=unexpected tx answer expected=none");
                end else begin
                    etx = q_tx.pop_front();
                    tg  = q_tx_tag.pop_front();
                    check(tg, 32'({tx_c_bit, tx_u_bit}), 32'(etx));
                end
            end
            if (host_rvld) begin
                if (q_rd.size() == 0) begin
                    n_chk++;
                    n_err++;
                    $display("FAIL R4 actual=unexpected read answer expected=none");
                end else begin
                    erd = q_rd.pop_front();
                    tg  = q_rd_tag.pop_front();
                    check(tg, 32'(host_rdata), 32'(erd));
                end
            end
        end
    end

    task automatic set_act(bit r, bit rc, bit tc);
        run_en = r;
        rx_clk_ok = rc;
        tx_clk_ok = tc;
        m_act = r && rc && tc;
        if (!m_act) t_on = 1'b0;
        @(negedge clk);
    endtask

    task automatic rx_stream(int pid, int nbits, int clash_addr);
        logic [BLK-1:0] bc, bu;
        bc = '0;
        bu = '0;
        for (int i = 0; i < nbits; i++) begin
            rx_bit_vld   = 1'b1;
            rx_blk_start = (i == 0);
            rx_c_bit     = pc(pid, i);
            rx_u_bit     = pu(pid, i);
            bc[i]        = pc(pid, i);
            bu[i]        = pu(pid, i);
            if (i == nbits - 1 && clash_addr >= 0) begin
                host_sel   = 1'b1;
                host_wr    = 1'b1;
                host_bsel  = 1'b0;
                host_addr  = AW'(clash_addr);
                host_wdata = 8'h5A;
            end
            @(negedge clk);
            host_sel = 1'b0;
            host_wr  = 1'b0;
        end
        rx_bit_vld   = 1'b0;
        rx_blk_start = 1'b0;
        if (nbits == BLK && m_act) begin
            m_e_c  = bc;
            m_e_u  = bu;
            m_flag = 1'b1;
        end
    endtask

    task automatic host_write(bit bs, int addr, logic [7:0] d);
        host_sel = 1'b1; host_wr = 1'b1; host_bsel = bs;
        host_addr = AW'(addr); host_wdata = d;
        if (m_act && addr < NB) begin
            if (bs) m_e_u[addr*8 +: 8] = d;
            else    m_e_c[addr*8 +: 8] = d;
        end
        @(negedge clk);
        host_sel = 1'b0; host_wr = 1'b0;
    endtask

    task automatic host_read(bit bs, int addr, string tag);
        logic [7:0] e;
        e = 8'h00;
        if (m_act && addr < NB) e = bs ? m_e_u[addr*8 +: 8] : m_e_c[addr*8 +: 8];
        q_rd.push_back(e);
        q_rd_tag.push_back(tag);
        host_sel = 1'b1; host_wr = 1'b0; host_bsel = bs; host_addr = AW'(addr);
        @(negedge clk);
        host_sel = 1'b0;
        m_flag = 1'b0;
    endtask

    task automatic tx_bits(int n, bit first_start, string tag);
        for (int i = 0; i < n; i++) begin
            tx_bit_req   = 1'b1;
            tx_blk_start = first_start && (i == 0);
            if (m_act) begin
                if (tx_blk_start) begin
                    m_f_c = m_e_c;
                    m_f_u = m_e_u;
                    t_on  = 1'b1;
                    t_ptr = 0;
                end
                if (t_on) begin
                    q_tx.push_back({m_f_c[t_ptr], m_f_u[t_ptr]});
                    q_tx_tag.push_back(tag);
                    t_ptr = (t_ptr + 1) % BLK;
                end
            end else begin
                t_on = 1'b0;
            end
            @(negedge clk);
        end
        tx_bit_req   = 1'b0;
        tx_blk_start = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    endtask

    initial begin : watchdog
        #(8 * 100000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", 32'(tx_bit_vld), 32'd0);
        check("R1", 32'(host_rvld), 32'd0);
        check("R1", 32'(e_updated), 32'd0);
        check("R1", 32'(host_rdata), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        host_read(1'b0, 5, "R1");
        host_read(1'b1, 40, "R1");

        // R7: no answer before a transmit block start
        tx_bits(4, 1'b0, "R7");

        // R2/R3: full capture block, then copy into host stage
        rx_stream(1, BLK, -1);
        check("R3", 32'(e_updated), 32'd1);
        for (int k = 0; k < NB; k++) begin
            host_read(1'b0, k, "R2");
            host_read(1'b1, k, "R2");
        end
        check("R6", 32'(e_updated), 32'd0);

        // R4: host writes to both sets
        host_write(1'b0, 3, 8'hA5);
        host_write(1'b1, 47, 8'h3C);
        host_read(1'b0, 3, "R4");
        host_read(1'b1, 47, "R4");
        host_read(1'b1, 3, "R4");

        // R11: addresses past the buffer
        host_write(1'b0, 50, 8'hFF);
        host_read(1'b0, 50, "R11");
        host_read(1'b0, 47, "R11");
        host_read(1'b1, 63, "R11");

        // R8: atomic transfer; edits during the block do not leak in
        tx_bits(10, 1'b1, "R8");
        host_write(1'b0, 0, 8'hFF);
        host_write(1'b0, 40, 8'h00);
        tx_bits(BLK - 10, 1'b0, "R8");
        // R9: repeat from index 0 without a new start
        tx_bits(3, 1'b0, "R9");
        tx_bits(4, 1'b1, "R8");

        // R3: partial block is discarded on a fresh start
        rx_stream(9, 100, -1);
        check("R3", 32'(e_updated), 32'd0);
        host_read(1'b0, 2, "R3");
        rx_stream(2, BLK, -1);
        check("R6", 32'(e_updated), 32'd1);
        host_read(1'b0, 0, "R3");
        host_read(1'b1, 20, "R3");
        host_read(1'b0, 47, "R3");

        // R5: copy beats a same-cycle host write
        rx_stream(4, BLK, 0);
        check("R6", 32'(e_updated), 32'd1);
        host_read(1'b0, 0, "R5");

        // R10: inactive block
        set_act(1'b0, 1'b1, 1'b1);
        host_write(1'b0, 1, 8'h77);
        host_read(1'b0, 1, "R10");
        rx_stream(5, BLK, -1);
        check("R10", 32'(e_updated), 32'd0);
        tx_bits(3, 1'b1, "R10");
        set_act(1'b1, 1'b0, 1'b1);
        tx_bits(2, 1'b1, "R10");
        set_act(1'b1, 1'b1, 1'b0);
        rx_stream(6, 20, -1);
        set_act(1'b1, 1'b1, 1'b1);
        host_read(1'b0, 1, "R10");
        host_read(1'b1, 1, "R10");
        tx_bits(2, 1'b0, "R10");
        tx_bits(3, 1'b1, "R8");

        repeat (4) @(negedge clk);
        check("R7", 32'(q_tx.size()), 32'd0);
        check("R4", 32'(q_rd.size()), 32'd0);
        finish_run();
    end

endmodule